// File: doc/BRIEF.md
# Packet Lane Serializer and Deserializer

This block sits between a memory controller core and a narrow, fast packet channel. The channel carries fixed-length packets of eight items per lane. On the transmit side, a wide parallel word is cut into one byte per lane, and each byte leaves as eight consecutive items. On the receive side, eight consecutive items per lane are gathered back into a byte, and the bytes are handed to the core as one wide word. One fast clock tick stands for one item slot, so two slots correspond to one cycle of a channel clock with data on both edges.

The channel has three lane groups, and each group is handled in both directions. The row command group has 3 lanes (24 bits per packet). The column command group has 5 lanes (40 bits). The data group has 18 lanes, formed from two byte groups of 9 lanes each, which carry 144 bits including parity. Each group in each direction has its own slot counter, its own 4-bit phase select and its own stop input. The core can therefore set where the parallel-word boundary falls within the serial stream, and can trim the offset between the row and column groups one slot at a time. Stopping a group freezes it, and when released it resumes at the same phase.

Top module: `lane_packet_serdes`

## Requirements
- R1: While rst_n is low, every serial output, every receive word and every receive valid is 0, and every slot counter is 0.
- R2: A transmit group's take output is high in a cycle exactly when that group is not stopped and the number of unstopped cycles since reset, modulo 8, equals its select modulo 8. Select bit 3 has no effect.
- R3: At the clock edge of a take cycle, the group samples its parallel input. Lane l's byte is bits [8l+7:8l]. From that edge on, lane l's serial output shows bit 0 of the byte, and each following unstopped edge moves to the next bit up to bit 7. If no new take occurs after bit 7, the output is 0.
- R4: The row, column and data groups each keep their own counter, select and stop, so different selects give packet boundaries that are offset from each other.
- R5: When a transmit group's stop is high at an edge, that edge leaves its serial outputs and its counter unchanged. After release, the group continues from the item and phase where it stopped.
- R6: On a receive group, each unstopped edge samples one item per lane. At an unstopped edge where the counter modulo 8 equals the select modulo 8, the word output takes, for each lane l, a byte at bits [8l+7:8l]. Bit j of that byte is the item sampled on the (j+1)-th of the eight sampling edges that end with this one, so bit 7 is the newest.
- R7: The receive valid output is high for the single cycle that follows each such edge. With a constant select, two valid cycles are never adjacent.
- R8: A receive group whose stop is high at an edge samples no item at that edge, keeps its counter, and raises no valid. The word output changes only at edges that raise valid.
- R9: The data group's 18 lanes (byte group A on lanes 0 to 8, byte group B on lanes 9 to 17) share one transmit select and stop, and one receive select and stop, and behave as a single group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast item clock, one item slot per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_row_par | input | 24 | Row command word to transmit, one byte per lane |
| tx_row_sel | input | 4 | Row transmit phase select (modulo 8) |
| tx_row_stop | input | 1 | Freeze row transmit group |
| tx_row_take | output | 1 | Row word is sampled at this cycle's edge |
| row_ser_out | output | 3 | Row serial items out |
| tx_col_par | input | 40 | Column command word to transmit |
| tx_col_sel | input | 4 | Column transmit phase select |
| tx_col_stop | input | 1 | Freeze column transmit group |
| tx_col_take | output | 1 | Column word is sampled at this cycle's edge |
| col_ser_out | output | 5 | Column serial items out |
| tx_dat_par | input | 144 | Data word to transmit, both byte groups |
| tx_dat_sel | input | 4 | Shared data transmit phase select |
| tx_dat_stop | input | 1 | Freeze data transmit group |
| tx_dat_take | output | 1 | Data word is sampled at this cycle's edge |
| dat_ser_out | output | 18 | Data serial items out |
| row_ser_in | input | 3 | Row serial items in |
| rx_row_sel | input | 4 | Row receive phase select |
| rx_row_stop | input | 1 | Freeze row receive group |
| rx_row_par | output | 24 | Gathered row word |
| rx_row_vld | output | 1 | One-cycle strobe for a new row word |
| col_ser_in | input | 5 | Column serial items in |
| rx_col_sel | input | 4 | Column receive phase select |
| rx_col_stop | input | 1 | Freeze column receive group |
| rx_col_par | output | 40 | Gathered column word |
| rx_col_vld | output | 1 | One-cycle strobe for a new column word |
| dat_ser_in | input | 18 | Data serial items in |
| rx_dat_sel | input | 4 | Shared data receive phase select |
| rx_dat_stop | input | 1 | Freeze data receive group |
| rx_dat_par | output | 144 | Gathered data word |
| rx_dat_vld | output | 1 | One-cycle strobe for a new data word |

## Verification
Each take output is combinational, so it is checked in the same cycle as the select, stop and counter state that cause it. A word sampled at a take edge shows its bit 0 on the serial outputs right after that edge, and each later unstopped edge shows the next bit. A receive word and its valid strobe appear right after the edge that completes the eighth item. The bench changes inputs just after each falling edge and compares the outputs 1 ns later. Before each rising edge it advances a slot-count reference model by exactly one edge, so every result is compared in the cycle in which it is due.

// File: rtl/lpx_pkg.sv
package lpx_pkg;
  // items per packet on every lane
  localparam int SLOTS = 8;
  localparam int CNT_W = $clog2(SLOTS);
  localparam int SEL_W = 4;

  // next slot index, wrapping at the packet length
  function automatic logic [CNT_W-1:0] slot_next(input logic [CNT_W-1:0] cnt);
    return cnt + CNT_W'(1);
  endfunction

  // the word boundary falls where the counter meets the select modulo SLOTS
  function automatic logic phase_hit(input logic [CNT_W-1:0] cnt,
                                     input logic [SEL_W-1:0] sel);
    return SEL_W'(cnt) == (sel & SEL_W'(SLOTS - 1));
  endfunction
endpackage

// File: rtl/lpx_slot_counter.sv
module lpx_slot_counter
  import lpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= slot_next(cnt_q);
  end

  assign hit = run && phase_hit(cnt_q, sel);
endmodule

// File: rtl/lpx_tx_group.sv
module lpx_tx_group
  import lpx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop,
  input  logic [SEL_W-1:0]       sel,
  input  logic [LANES*SLOTS-1:0] par,
  output logic [LANES-1:0]       ser,
  output logic                   take
);
  logic run;
  logic hit;

  assign run = !stop;

  lpx_slot_counter u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (sel),
    .hit   (hit)
  );

  assign take = hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-2:0] pend_q;   // items still waiting to leave
    logic             item_q;   // item on the lane now

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= '0;
        item_q <= 1'b0;
      end else if (run) begin
        if (hit) begin
          item_q <= par[l*SLOTS];
          pend_q <= par[l*SLOTS+1 +: SLOTS-1];
        end else begin
          item_q <= pend_q[0];
          pend_q <= {1'b0, pend_q[SLOTS-2:1]};
        end
      end
    end

    assign ser[l] = item_q;
  end
endmodule

// File: rtl/lpx_rx_group.sv
module lpx_rx_group
  import lpx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop,
  input  logic [SEL_W-1:0]       sel,
  input  logic [LANES-1:0]       ser,
  output logic [LANES*SLOTS-1:0] par,
  output logic                   vld
);
  logic run;
  logic hit;

  assign run = !stop;

  lpx_slot_counter u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (sel),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= hit;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-2:0] hist_q;   // the seven most recent items, newest on top
    logic [SLOTS-1:0] gathered;
    logic [SLOTS-1:0] word_q;

    assign gathered = {ser[l], hist_q};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_q <= '0;
        word_q <= '0;
      end else if (run) begin
        hist_q <= gathered[SLOTS-1:1];
        if (hit) word_q <= gathered;
      end
    end

    assign par[l*SLOTS +: SLOTS] = word_q;
  end
endmodule

// File: rtl/lane_packet_serdes.sv
module lane_packet_serdes #(
  parameter int ROW_LANES     = 3,
  parameter int COL_LANES     = 5,
  parameter int DAT_BYTE_LANES = 9,
  parameter int DAT_BYTES     = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ROW_LANES*8-1:0]                tx_row_par,
  input  logic [3:0]                            tx_row_sel,
  input  logic                                  tx_row_stop,
  output logic                                  tx_row_take,
  output logic [ROW_LANES-1:0]                  row_ser_out,
  input  logic [COL_LANES*8-1:0]                tx_col_par,
  input  logic [3:0]                            tx_col_sel,
  input  logic                                  tx_col_stop,
  output logic                                  tx_col_take,
  output logic [COL_LANES-1:0]                  col_ser_out,
  input  logic [DAT_BYTE_LANES*DAT_BYTES*8-1:0] tx_dat_par,
  input  logic [3:0]                            tx_dat_sel,
  input  logic                                  tx_dat_stop,
  output logic                                  tx_dat_take,
  output logic [DAT_BYTE_LANES*DAT_BYTES-1:0]   dat_ser_out,
  input  logic [ROW_LANES-1:0]                  row_ser_in,
  input  logic [3:0]                            rx_row_sel,
  input  logic                                  rx_row_stop,
  output logic [ROW_LANES*8-1:0]                rx_row_par,
  output logic                                  rx_row_vld,
  input  logic [COL_LANES-1:0]                  col_ser_in,
  input  logic [3:0]                            rx_col_sel,
  input  logic                                  rx_col_stop,
  output logic [COL_LANES*8-1:0]                rx_col_par,
  output logic                                  rx_col_vld,
  input  logic [DAT_BYTE_LANES*DAT_BYTES-1:0]   dat_ser_in,
  input  logic [3:0]                            rx_dat_sel,
  input  logic                                  rx_dat_stop,
  output logic [DAT_BYTE_LANES*DAT_BYTES*8-1:0] rx_dat_par,
  output logic                                  rx_dat_vld
);
  // both data byte groups run as one group under a shared select and stop
  localparam int DAT_LANES = DAT_BYTE_LANES * DAT_BYTES;

  lpx_tx_group #(.LANES(ROW_LANES)) u_tx_row (
    .clk (clk), .rst_n (rst_n), .stop (tx_row_stop), .sel (tx_row_sel),
    .par (tx_row_par), .ser (row_ser_out), .take (tx_row_take)
  );

  lpx_tx_group #(.LANES(COL_LANES)) u_tx_col (
    .clk (clk), .rst_n (rst_n), .stop (tx_col_stop), .sel (tx_col_sel),
    .par (tx_col_par), .ser (col_ser_out), .take (tx_col_take)
  );

  lpx_tx_group #(.LANES(DAT_LANES)) u_tx_dat (
    .clk (clk), .rst_n (rst_n), .stop (tx_dat_stop), .sel (tx_dat_sel),
    .par (tx_dat_par), .ser (dat_ser_out), .take (tx_dat_take)
  );

  lpx_rx_group #(.LANES(ROW_LANES)) u_rx_row (
    .clk (clk), .rst_n (rst_n), .stop (rx_row_stop), .sel (rx_row_sel),
    .ser (row_ser_in), .par (rx_row_par), .vld (rx_row_vld)
  );

  lpx_rx_group #(.LANES(COL_LANES)) u_rx_col (
    .clk (clk), .rst_n (rst_n), .stop (rx_col_stop), .sel (rx_col_sel),
    .ser (col_ser_in), .par (rx_col_par), .vld (rx_col_vld)
  );

  lpx_rx_group #(.LANES(DAT_LANES)) u_rx_dat (
    .clk (clk), .rst_n (rst_n), .stop (rx_dat_stop), .sel (rx_dat_sel),
    .ser (dat_ser_in), .par (rx_dat_par), .vld (rx_dat_vld)
  );
endmodule

// File: rtl/lane_packet_serdes_chk.sv
module lane_packet_serdes_chk #(
  parameter int ROW_LANES     = 3,
  parameter int COL_LANES     = 5,
  parameter int DAT_BYTE_LANES = 9,
  parameter int DAT_BYTES     = 2
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [ROW_LANES*8-1:0]                tx_row_par,
  input logic                                  tx_row_stop,
  input logic                                  tx_row_take,
  input logic [ROW_LANES-1:0]                  row_ser_out,
  input logic [3:0]                            tx_col_sel,
  input logic                                  tx_col_take,
  input logic                                  tx_dat_stop,
  input logic [DAT_BYTE_LANES*DAT_BYTES-1:0]   dat_ser_out,
  input logic [3:0]                            rx_row_sel,
  input logic                                  rx_row_vld,
  input logic                                  rx_col_stop,
  input logic                                  rx_col_vld,
  input logic [DAT_BYTE_LANES*DAT_BYTES*8-1:0] rx_dat_par,
  input logic                                  rx_dat_vld
);
  // bit 0 of every row lane byte, the first item each lane must send
  logic [ROW_LANES-1:0] row_first;
  for (genvar l = 0; l < ROW_LANES; l++) begin : g_first
    assign row_first[l] = tx_row_par[l*8];
  end

  // R5
  tx_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_row_stop |=> $stable(row_ser_out));

  // R5
  tx_dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dat_stop |=> $stable(dat_ser_out));

  // R3
  tx_row_first_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_row_take |=> (row_ser_out == $past(row_first)));

  // R2
  tx_col_take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_col_take |=> (!tx_col_take || !$stable(tx_col_sel)));

  // R8
  rx_col_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_col_stop |=> !rx_col_vld);

  // R7
  rx_row_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_row_vld && $stable(rx_row_sel)) |=> !rx_row_vld);

  // R8
  rx_dat_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dat_vld |-> $stable(rx_dat_par));
endmodule

bind lane_packet_serdes lane_packet_serdes_chk #(
  .ROW_LANES      (ROW_LANES),
  .COL_LANES      (COL_LANES),
  .DAT_BYTE_LANES (DAT_BYTE_LANES),
  .DAT_BYTES      (DAT_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_row_par  (tx_row_par),
  .tx_row_stop (tx_row_stop),
  .tx_row_take (tx_row_take),
  .row_ser_out (row_ser_out),
  .tx_col_sel  (tx_col_sel),
  .tx_col_take (tx_col_take),
  .tx_dat_stop (tx_dat_stop),
  .dat_ser_out (dat_ser_out),
  .rx_row_sel  (rx_row_sel),
  .rx_row_vld  (rx_row_vld),
  .rx_col_stop (rx_col_stop),
  .rx_col_vld  (rx_col_vld),
  .rx_dat_par  (rx_dat_par),
  .rx_dat_vld  (rx_dat_vld)
);

// File: tb/test_lane_packet_serdes.sv
module test_lane_packet_serdes;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  int lanes [3] = '{3, 5, 18};

  // stimulus, indexed by group: 0 row, 1 column, 2 data
  logic [143:0] tpar  [3];
  logic [3:0]   tsel  [3];
  logic         tstop [3];
  logic [17:0]  rser  [3];
  logic [3:0]   rsel  [3];
  logic         rstop [3];

  // design outputs gathered per group
  logic [17:0]  ser_o  [3];
  logic         take_o [3];
  logic [143:0] rpar_o [3];
  logic         rvld_o [3];

  logic [2:0]   row_ser_out;
  logic [4:0]   col_ser_out;
  logic [17:0]  dat_ser_out;
  logic [23:0]  rx_row_par;
  logic [39:0]  rx_col_par;
  logic [143:0] rx_dat_par;
  logic         tx_row_take, tx_col_take, tx_dat_take;
  logic         rx_row_vld, rx_col_vld, rx_dat_vld;

  lane_packet_serdes i_lane_packet_serdes (
    .clk (clk), .rst_n (rst_n),
    .tx_row_par (tpar[0][23:0]), .tx_row_sel (tsel[0]), .tx_row_stop (tstop[0]),
    .tx_row_take (tx_row_take), .row_ser_out (row_ser_out),
    .tx_col_par (tpar[1][39:0]), .tx_col_sel (tsel[1]), .tx_col_stop (tstop[1]),
    .tx_col_take (tx_col_take), .col_ser_out (col_ser_out),
    .tx_dat_par (tpar[2]), .tx_dat_sel (tsel[2]), .tx_dat_stop (tstop[2]),
    .tx_dat_take (tx_dat_take), .dat_ser_out (dat_ser_out),
    .row_ser_in (rser[0][2:0]), .rx_row_sel (rsel[0]), .rx_row_stop (rstop[0]),
    .rx_row_par (rx_row_par), .rx_row_vld (rx_row_vld),
    .col_ser_in (rser[1][4:0]), .rx_col_sel (rsel[1]), .rx_col_stop (rstop[1]),
    .rx_col_par (rx_col_par), .rx_col_vld (rx_col_vld),
    .dat_ser_in (rser[2]), .rx_dat_sel (rsel[2]), .rx_dat_stop (rstop[2]),
    .rx_dat_par (rx_dat_par), .rx_dat_vld (rx_dat_vld)
  );

  always_comb begin
    ser_o[0] = {15'b0, row_ser_out};
    ser_o[1] = {13'b0, col_ser_out};
    ser_o[2] = dat_ser_out;
    take_o[0] = tx_row_take;
    take_o[1] = tx_col_take;
    take_o[2] = tx_dat_take;
    rpar_o[0] = {120'b0, rx_row_par};
    rpar_o[1] = {104'b0, rx_col_par};
    rpar_o[2] = rx_dat_par;
    rvld_o[0] = rx_row_vld;
    rvld_o[1] = rx_col_vld;
    rvld_o[2] = rx_dat_vld;
  end

  // reference model: unstopped-edge counts, the last word taken and the item shown
  int           m_cnt  [3];
  logic [143:0] m_word [3];
  int           m_idx  [3];
  int           m_rcnt [3];
  logic [17:0]  m_hist [3][8];
  logic [143:0] m_rpar [3];
  logic         m_rvld [3];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic model_reset();
    for (int g = 0; g < 3; g++) begin
      m_cnt[g] = 0; m_word[g] = '0; m_idx[g] = 8;
      m_rcnt[g] = 0; m_rpar[g] = '0; m_rvld[g] = 1'b0;
      for (int k = 0; k < 8; k++) m_hist[g][k] = '0;
    end
  endtask

  function automatic logic [17:0] exp_ser(int g);
    logic [17:0] r = '0;
    for (int l = 0; l < lanes[g]; l++)
      r[l] = (m_idx[g] < 8) ? m_word[g][l*8 + m_idx[g]] : 1'b0;
    return r;
  endfunction

  function automatic logic exp_take(int g);
    return !tstop[g] && (m_cnt[g] == int'(tsel[g] % 4'd8));
  endfunction

  task automatic chk(bit ok, string req, string tag, int g, logic [143:0] act, logic [143:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] group %0d%s: actual %h expected %h", req, tag, g,
               (g == 2) ? " (R9)" : "", act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int g = 0; g < 3; g++) begin
      chk(ser_o[g] == exp_ser(g), "R3", tag, g, 144'(ser_o[g]), 144'(exp_ser(g)));
      chk(take_o[g] == exp_take(g), "R2", tag, g, 144'(take_o[g]), 144'(exp_take(g)));
      chk(rpar_o[g] == m_rpar[g], "R6", tag, g, rpar_o[g], m_rpar[g]);
      chk(rvld_o[g] == m_rvld[g], "R7", tag, g, 144'(rvld_o[g]), 144'(m_rvld[g]));
    end
  endtask

  // advance the model across the coming rising edge
  task automatic model_step();
    for (int g = 0; g < 3; g++) begin
      if (!tstop[g]) begin
        if (exp_take(g)) begin
          m_word[g] = tpar[g];
          m_idx[g] = 0;
        end else if (m_idx[g] < 8) begin
          m_idx[g]++;
        end
        m_cnt[g] = (m_cnt[g] + 1) % 8;
      end
      if (!rstop[g]) begin
        for (int k = 0; k < 7; k++) m_hist[g][k] = m_hist[g][k+1];
        m_hist[g][7] = rser[g];
        if (m_rcnt[g] == int'(rsel[g] % 4'd8)) begin
          for (int l = 0; l < lanes[g]; l++)
            for (int j = 0; j < 8; j++)
              m_rpar[g][l*8 + j] = m_hist[g][j][l];
          m_rvld[g] = 1'b1;
        end else begin
          m_rvld[g] = 1'b0;
        end
        m_rcnt[g] = (m_rcnt[g] + 1) % 8;
      end else begin
        m_rvld[g] = 1'b0;
      end
    end
  endtask

  // inputs are set just after a falling edge; check 1 ns later, then cross one rising edge
  task automatic cycle(string tag);
    #1;
    check_all(tag);
    model_step();
    @(negedge clk);
  endtask

  function automatic logic [143:0] rand_word();
    logic [143:0] w;
    for (int k = 0; k < 5; k++) w[k*32 +: 32] = $urandom();
    return w;
  endfunction

  task automatic rand_data();
    for (int g = 0; g < 3; g++) begin
      tpar[g] = rand_word();
      rser[g] = 18'($urandom());
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0421));
    rst_n = 1'b0;
    for (int g = 0; g < 3; g++) begin
      tpar[g] = '1; tsel[g] = '0; tstop[g] = 1'b0;
      rser[g] = '1; rsel[g] = '0; rstop[g] = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs cleared while reset is held, even with inputs all ones
    for (int g = 0; g < 3; g++) begin
      chk(ser_o[g] == '0, "R1", "reset", g, 144'(ser_o[g]), '0);
      chk(rpar_o[g] == '0, "R1", "reset", g, rpar_o[g], '0);
      chk(rvld_o[g] == 1'b0, "R1", "reset", g, 144'(rvld_o[g]), '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();

    // R1: counters start at 0, so select 0 gives a take in the first cycle
    for (int g = 0; g < 3; g++) tpar[g] = {9{16'hA5C3}};
    for (int i = 0; i < 24; i++) begin
      for (int g = 0; g < 3; g++) rser[g] = 18'($urandom());
      cycle("R1 R3 sel0");
    end

    // R4: distinct selects per group, data select has bit 3 set (R2)
    tsel[0] = 4'd2; tsel[1] = 4'd5; tsel[2] = 4'd11;
    rsel[0] = 4'd1; rsel[1] = 4'd6; rsel[2] = 4'd12;
    for (int i = 0; i < 32; i++) begin
      rand_data();
      cycle("R4 offsets");
    end

    // R5 R8: stop patterns held for several cycles and released
    for (int i = 0; i < 40; i++) begin
      rand_data();
      tstop[0] = (i % 3) == 0;
      tstop[1] = (i >= 5) && (i < 14);
      tstop[2] = (i % 7) < 2;
      rstop[0] = (i % 4) == 1;
      rstop[1] = (i >= 10) && (i < 21);
      rstop[2] = (i % 5) == 3;
      cycle("R5 R8 stops");
    end

    // constrained random: stops about one cycle in four, rare select changes
    for (int i = 0; i < 3000; i++) begin
      rand_data();
      for (int g = 0; g < 3; g++) begin
        tstop[g] = ($urandom() % 4) == 0;
        rstop[g] = ($urandom() % 4) == 0;
        if (($urandom() % 50) == 0) tsel[g] = 4'($urandom());
        if (($urandom() % 50) == 0) rsel[g] = 4'($urandom());
      end
      cycle("random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule